// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard logic for a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and write-back. Each cycle it reads the register numbers and control bits carried by the stage registers. It returns three kinds of result:

- operand-bypass selects for the two execute-stage ALU inputs;
- a stall that freezes the PC and the fetch/decode register and empties the control bits entering execute;
- a redirect for conditional branches, which are settled in decode.

A branch resolved in decode costs one fetched instruction when taken. The block clears the fetch/decode register and steers the PC to the branch target. The branch comparator in decode is fed from the register-file read values. Those values are first bypassed from the memory-stage ALU result or the write-back data when a newer producer holds the same register.

All outputs are combinational functions of the current inputs. The surrounding pipeline applies them at the next clock edge. The stage registers, the ALU and the register file are outside this block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An execute-stage source register is bypassed from the memory stage (select code 2'b10) when the memory-stage instruction writes a register, its destination is nonzero and equals that source.
- R2: When R1 does not apply and the write-back instruction writes a nonzero destination equal to the source, the select is 2'b01; otherwise it is 2'b00 (register-file value).
- R3: When both the memory and write-back stages match the same source, the memory-stage bypass (2'b10) is chosen.
- R4: No bypass is selected from a stage whose destination is register 0 or whose register-write bit is clear.
- R5: A load in execute whose nonzero destination equals a source register that the decode instruction actually reads raises stall. A matching source that the decode instruction does not read raises no stall.
- R6: A branch in decode raises stall in two cases: when the execute-stage instruction writes a nonzero register equal to either branch operand, or when a load in the memory stage has such a destination. A non-branch instruction behind a memory-stage load is not stalled.
- R7: The decode comparator takes each operand from the memory-stage result if a non-load there writes the matching nonzero register. Failing that, it takes the write-back data on a match. Otherwise it takes the register-file value.
- R8: An equal-test branch (is_bne=0) is taken when the two operands are equal. A not-equal branch (is_bne=1) is taken when they differ. A taken branch raises pc_sel and flush_ifid in the same cycle.
- R9: While stall is high, pc_sel and flush_ifid stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| id_uses_rs | input | 1 | Decode instruction reads id_rs |
| id_uses_rt | input | 1 | Decode instruction reads id_rt |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_is_bne | input | 1 | Branch tests not-equal (0: tests equal) |
| id_rs_val | input | DW | Register-file value for id_rs |
| id_rt_val | input | DW | Register-file value for id_rt |
| ex_rs | input | REG_AW | First source register in execute |
| ex_rt | input | REG_AW | Second source register in execute |
| ex_dst | input | REG_AW | Destination register in execute |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_AW | Destination register in memory stage |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_result | input | DW | ALU result held in the memory stage |
| wb_dst | input | REG_AW | Destination register in write-back |
| wb_reg_write | input | 1 | Write-back instruction writes a register |
| wb_result | input | DW | Data being written back |
| fwd_a | output | 2 | Bypass select for ALU input A |
| fwd_b | output | 2 | Bypass select for ALU input B |
| stall | output | 1 | Hold PC and fetch/decode register, bubble into execute |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| pc_sel | output | 1 | Load the branch target into the PC |

## Verification
The bench concentrates on the corners where one wrong condition goes unnoticed in ordinary code.

- Both bypass stages target the same register. A design with the priority reversed would feed stale write-back data to the ALU.
- A hazard involves register 0. A design that forgets the zero check would stall or bypass on writes that never happen.
- A load in execute matches a source the decode instruction does not read. A design that ignores the use bits would insert needless bubbles.
- A branch follows an ALU result or a load by one or two slots. A design with a wrong stall or comparator bypass would redirect on old register values, or redirect while it is stalled.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_REGFILE  = 2'b00,
    FWD_FROM_WB  = 2'b01,
    FWD_FROM_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one source register against the two later producers.
module hz_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_we,
  output logic              hit_mem,
  output logic              hit_wb
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit_mem = mem_we && (mem_dst != ZERO_REG) && (mem_dst == src);
    hit_wb  = wb_we  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
  end
endmodule

// File: rtl/hz_ex_forward.sv
// Bypass selects for the execute-stage ALU operands.
module hz_ex_forward
  import hz_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int N_OPS  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_OPS-1:0][REG_AW-1:0] src,
  input  logic [REG_AW-1:0]           mem_dst,
  input  logic                        mem_we,
  input  logic [REG_AW-1:0]           wb_dst,
  input  logic                        wb_we,
  output fwd_sel_e [N_OPS-1:0]        sel
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    logic hit_mem, hit_wb;

    hz_src_match #(.REG_AW(REG_AW)) u_match (
      .src    (src[i]),
      .mem_dst(mem_dst),
      .mem_we (mem_we),
      .wb_dst (wb_dst),
      .wb_we  (wb_we),
      .hit_mem(hit_mem),
      .hit_wb (hit_wb)
    );

    always_comb begin
      if (hit_mem)     sel[i] = FWD_FROM_MEM;
      else if (hit_wb) sel[i] = FWD_FROM_WB;
      else             sel[i] = FWD_REGFILE;
    end

    // Bypass from memory stage only when that stage really writes src
    assert_mem_fwd_valid_R1: assert property (@(posedge clk) disable iff (rst)
      (sel[i] == FWD_FROM_MEM) |-> (mem_we && mem_dst == src[i]));
    // Write-back bypass only when write-back really writes src
    assert_wb_fwd_valid_R2: assert property (@(posedge clk) disable iff (rst)
      (sel[i] == FWD_FROM_WB) |-> (wb_we && wb_dst == src[i]));
    // Both stages match: memory stage wins
    assert_mem_priority_R3: assert property (@(posedge clk) disable iff (rst)
      (mem_we && wb_we && mem_dst == src[i] && wb_dst == src[i] && src[i] != '0)
        |-> (sel[i] == FWD_FROM_MEM));
    // Register 0 never bypassed
    assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
      (src[i] == '0) |-> (sel[i] == FWD_REGFILE));
  end
endmodule

// File: rtl/hz_stall_detect.sv
// Load-use and branch-operand stall detection in decode.
module hz_stall_detect #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_uses_rs,
  input  logic              id_uses_rt,
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_reg_write,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_mem_read,
  output logic              stall
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic ex_hits_rs, ex_hits_rt, mem_hits_any;
  logic load_use, branch_wait;

  always_comb begin
    ex_hits_rs   = (ex_dst != ZERO_REG) && (ex_dst == id_rs);
    ex_hits_rt   = (ex_dst != ZERO_REG) && (ex_dst == id_rt);
    mem_hits_any = (mem_dst != ZERO_REG) && ((mem_dst == id_rs) || (mem_dst == id_rt));
    load_use     = ex_mem_read && ((id_uses_rs && ex_hits_rs) || (id_uses_rt && ex_hits_rt));
    branch_wait  = id_is_branch &&
                   ((ex_reg_write && (ex_hits_rs || ex_hits_rt)) ||
                    (mem_mem_read && mem_hits_any));
    stall        = load_use || branch_wait;
  end

  assert_load_use_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (ex_mem_read && id_uses_rs && ex_dst == id_rs && id_rs != '0) |-> stall);
  assert_unused_src_R5: assert property (@(posedge clk) disable iff (rst)
    (!id_is_branch && !id_uses_rs && !id_uses_rt) |-> !stall);
  assert_branch_after_alu_R6: assert property (@(posedge clk) disable iff (rst)
    (id_is_branch && ex_reg_write && ex_dst == id_rt && id_rt != '0) |-> stall);
endmodule

// File: rtl/hz_id_branch.sv
// Decode-stage branch comparator with its own operand bypass.
module hz_id_branch #(
  parameter int REG_AW = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [DW-1:0]     id_rs_val,
  input  logic [DW-1:0]     id_rt_val,
  input  logic              is_branch,
  input  logic              is_bne,
  input  logic              hold,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_fwd_en,
  input  logic [DW-1:0]     mem_result,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_we,
  input  logic [DW-1:0]     wb_result,
  output logic              taken
);
  localparam int N_CMP = 2;

  logic [N_CMP-1:0][REG_AW-1:0] srcs;
  logic [N_CMP-1:0][DW-1:0]     rf_vals;
  logic [N_CMP-1:0][DW-1:0]     opnd;
  logic                         same;

  assign srcs    = {id_rt, id_rs};
  assign rf_vals = {id_rt_val, id_rs_val};

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    logic hit_mem, hit_wb;

    hz_src_match #(.REG_AW(REG_AW)) u_match (
      .src    (srcs[i]),
      .mem_dst(mem_dst),
      .mem_we (mem_fwd_en),
      .wb_dst (wb_dst),
      .wb_we  (wb_we),
      .hit_mem(hit_mem),
      .hit_wb (hit_wb)
    );

    always_comb begin
      if (hit_mem)     opnd[i] = mem_result;
      else if (hit_wb) opnd[i] = wb_result;
      else             opnd[i] = rf_vals[i];
    end
  end

  always_comb begin
    same  = (opnd[0] == opnd[1]);
    taken = is_branch && !hold && (is_bne ? !same : same);
  end

  assert_taken_needs_branch_R8: assert property (@(posedge clk) disable iff (rst)
    taken |-> is_branch);
  assert_no_taken_on_hold_R9: assert property (@(posedge clk) disable iff (rst)
    hold |-> !taken);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_uses_rs,
  input  logic              id_uses_rt,
  input  logic              id_is_branch,
  input  logic              id_is_bne,
  input  logic [DW-1:0]     id_rs_val,
  input  logic [DW-1:0]     id_rt_val,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_reg_write,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_reg_write,
  input  logic              mem_mem_read,
  input  logic [DW-1:0]     mem_result,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_reg_write,
  input  logic [DW-1:0]     wb_result,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              stall,
  output logic              flush_ifid,
  output logic              pc_sel
);
  localparam int N_ALU_OPS = 2;

  fwd_sel_e [N_ALU_OPS-1:0]        ex_sel;
  logic     [N_ALU_OPS-1:0][REG_AW-1:0] ex_srcs;
  logic                            stall_int;
  logic                            br_taken;
  logic                            mem_alu_ready;

  assign ex_srcs       = {ex_rt, ex_rs};
  assign mem_alu_ready = mem_reg_write && !mem_mem_read;

  hz_ex_forward #(.REG_AW(REG_AW), .N_OPS(N_ALU_OPS)) u_exfwd (
    .clk    (clk),
    .rst    (rst),
    .src    (ex_srcs),
    .mem_dst(mem_dst),
    .mem_we (mem_reg_write),
    .wb_dst (wb_dst),
    .wb_we  (wb_reg_write),
    .sel    (ex_sel)
  );

  hz_stall_detect #(.REG_AW(REG_AW)) u_stall (
    .clk         (clk),
    .rst         (rst),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_uses_rs  (id_uses_rs),
    .id_uses_rt  (id_uses_rt),
    .id_is_branch(id_is_branch),
    .ex_dst      (ex_dst),
    .ex_reg_write(ex_reg_write),
    .ex_mem_read (ex_mem_read),
    .mem_dst     (mem_dst),
    .mem_mem_read(mem_mem_read),
    .stall       (stall_int)
  );

  hz_id_branch #(.REG_AW(REG_AW), .DW(DW)) u_branch (
    .clk       (clk),
    .rst       (rst),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .id_rs_val (id_rs_val),
    .id_rt_val (id_rt_val),
    .is_branch (id_is_branch),
    .is_bne    (id_is_bne),
    .hold      (stall_int),
    .mem_dst   (mem_dst),
    .mem_fwd_en(mem_alu_ready),
    .mem_result(mem_result),
    .wb_dst    (wb_dst),
    .wb_we     (wb_reg_write),
    .wb_result (wb_result),
    .taken     (br_taken)
  );

  always_comb begin
    fwd_a      = ex_sel[0];
    fwd_b      = ex_sel[1];
    stall      = stall_int;
    flush_ifid = br_taken;
    pc_sel     = br_taken;
  end

  assert_redirect_pairs_flush_R8: assert property (@(posedge clk) disable iff (rst)
    pc_sel |-> flush_ifid);
  assert_quiet_in_stall_R9: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!pc_sel && !flush_ifid));
  assert_mem_load_no_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (!id_is_branch && !ex_mem_read) |-> !stall);
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0;
  logic rst = 1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic id_uses_rs, id_uses_rt, id_is_branch, id_is_bne;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write;
  logic [DW-1:0] id_rs_val, id_rt_val, mem_result, wb_result;
  logic [1:0] fwd_a, fwd_b;
  logic stall, flush_ifid, pc_sel;

  int n_vec = 0;
  int n_bad = 0;

  pipe_hazard_ctrl #(.REG_AW(AW), .DW(DW)) uut (.*);

  task automatic clear_in();
    id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0; ex_dst = 0; mem_dst = 0; wb_dst = 0;
    id_uses_rs = 0; id_uses_rt = 0; id_is_branch = 0; id_is_bne = 0;
    ex_reg_write = 0; ex_mem_read = 0; mem_reg_write = 0; mem_mem_read = 0; wb_reg_write = 0;
    id_rs_val = 0; id_rt_val = 0; mem_result = 0; wb_result = 0;
  endtask

  // Behavioural reference, written from the requirements
  function automatic int ref_sel(int src);
    if (mem_reg_write && mem_dst != 0 && int'(mem_dst) == src) return 2;
    if (wb_reg_write && wb_dst != 0 && int'(wb_dst) == src) return 1;
    return 0;
  endfunction

  function automatic longint ref_opnd(int src, longint rf);
    if (mem_reg_write && !mem_mem_read && mem_dst != 0 && int'(mem_dst) == src) return mem_result;
    if (wb_reg_write && wb_dst != 0 && int'(wb_dst) == src) return wb_result;
    return rf;
  endfunction

  task automatic check(string tag);
    int e_a, e_b;
    bit e_st, e_tk, ld, br;
    longint a, b;
    e_a = ref_sel(int'(ex_rs));
    e_b = ref_sel(int'(ex_rt));
    ld = ex_mem_read && ex_dst != 0 &&
         ((id_uses_rs && ex_dst == id_rs) || (id_uses_rt && ex_dst == id_rt));
    br = id_is_branch &&
         ((ex_reg_write && ex_dst != 0 && (ex_dst == id_rs || ex_dst == id_rt)) ||
          (mem_mem_read && mem_dst != 0 && (mem_dst == id_rs || mem_dst == id_rt)));
    e_st = ld || br;
    a = ref_opnd(int'(id_rs), id_rs_val);
    b = ref_opnd(int'(id_rt), id_rt_val);
    e_tk = id_is_branch && !e_st && (id_is_bne ? (a != b) : (a == b));
    n_vec++;
    if (int'(fwd_a) != e_a || int'(fwd_b) != e_b || stall != e_st ||
        pc_sel != e_tk || flush_ifid != e_tk) begin
      n_bad++;
      $display("FAIL %s: got fwd_a=%0d fwd_b=%0d stall=%0b pc_sel=%0b flush=%0b, expected fwd_a=%0d fwd_b=%0d stall=%0b pc_sel=%0b flush=%0b",
               tag, fwd_a, fwd_b, stall, pc_sel, flush_ifid, e_a, e_b, e_st, e_tk, e_tk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got no completion, expected end of stimulus");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    #1 check("R4 reset state, all idle");
    rst = 0;

    // R1: memory-stage bypass
    @(negedge clk); clear_in(); ex_rs = 3; mem_dst = 3; mem_reg_write = 1;
    #1 check("R1 mem bypass on A");
    // R2: write-back bypass
    @(negedge clk); clear_in(); ex_rt = 7; wb_dst = 7; wb_reg_write = 1;
    #1 check("R2 wb bypass on B");
    // R3: both match
    @(negedge clk); clear_in(); ex_rs = 4; ex_rt = 4; mem_dst = 4; wb_dst = 4;
    mem_reg_write = 1; wb_reg_write = 1;
    #1 check("R3 mem priority over wb");
    // R4: register zero and disabled write
    @(negedge clk); clear_in(); mem_reg_write = 1; wb_reg_write = 1;
    #1 check("R4 dest zero no bypass");
    @(negedge clk); clear_in(); ex_rs = 5; mem_dst = 5; wb_dst = 5;
    #1 check("R4 write disabled no bypass");
    // R5: load-use
    @(negedge clk); clear_in(); ex_mem_read = 1; ex_reg_write = 1; ex_dst = 9;
    id_rt = 9; id_uses_rt = 1;
    #1 check("R5 load-use stall");
    @(negedge clk); clear_in(); ex_mem_read = 1; ex_reg_write = 1; ex_dst = 9;
    id_rt = 9; id_uses_rt = 0;
    #1 check("R5 unused source no stall");
    @(negedge clk); clear_in(); ex_mem_read = 1; ex_reg_write = 1;
    id_uses_rs = 1;
    #1 check("R5 load to reg zero no stall");
    // R6: branch waits on producer
    @(negedge clk); clear_in(); id_is_branch = 1; id_rs = 2; id_rt = 6;
    ex_reg_write = 1; ex_dst = 6;
    #1 check("R6 branch behind ALU op stalls");
    @(negedge clk); clear_in(); id_is_branch = 1; id_rs = 2; id_rt = 6;
    mem_reg_write = 1; mem_mem_read = 1; mem_dst = 2;
    #1 check("R6 branch behind mem load stalls");
    @(negedge clk); clear_in(); id_uses_rs = 1; id_rs = 2;
    mem_reg_write = 1; mem_mem_read = 1; mem_dst = 2;
    #1 check("R6 non-branch behind mem load no stall");
    // R7/R8: comparator bypass and polarity
    @(negedge clk); clear_in(); id_is_branch = 1; id_rs = 1; id_rt = 2;
    id_rs_val = 10; id_rt_val = 99; mem_reg_write = 1; mem_dst = 2; mem_result = 10;
    #1 check("R7 R8 beq taken via mem bypass");
    @(negedge clk); clear_in(); id_is_branch = 1; id_rs = 1; id_rt = 2;
    id_rs_val = 10; id_rt_val = 10; wb_reg_write = 1; wb_dst = 1; wb_result = 11;
    #1 check("R7 beq not taken via wb bypass");
    @(negedge clk); clear_in(); id_is_branch = 1; id_is_bne = 1; id_rs = 1; id_rt = 2;
    id_rs_val = 5; id_rt_val = 6;
    #1 check("R8 bne taken");
    @(negedge clk); clear_in(); id_is_branch = 1; id_is_bne = 1; id_rs = 3; id_rt = 3;
    id_rs_val = 5; id_rt_val = 5;
    #1 check("R8 bne not taken");
    // R9: stall suppresses redirect
    @(negedge clk); clear_in(); id_is_branch = 1; id_rs = 1; id_rt = 2;
    id_rs_val = 4; id_rt_val = 4; ex_reg_write = 1; ex_dst = 1;
    #1 check("R9 no redirect in stall");

    // Mixed patterns over a small register space
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      id_rs = AW'($urandom % 4); id_rt = AW'($urandom % 4);
      ex_rs = AW'($urandom % 4); ex_rt = AW'($urandom % 4);
      ex_dst = AW'($urandom % 4); mem_dst = AW'($urandom % 4); wb_dst = AW'($urandom % 4);
      id_uses_rs = 1'($urandom); id_uses_rt = 1'($urandom);
      id_is_branch = 1'($urandom); id_is_bne = 1'($urandom);
      ex_mem_read = 1'($urandom); ex_reg_write = ex_mem_read | 1'($urandom);
      mem_mem_read = 1'($urandom); mem_reg_write = mem_mem_read | 1'($urandom);
      wb_reg_write = 1'($urandom);
      id_rs_val = DW'($urandom % 3); id_rt_val = DW'($urandom % 3);
      mem_result = DW'($urandom % 3); wb_result = DW'($urandom % 3);
      #1 check("R1 R3 R5 R6 R7 R8 R9 mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule